// File: doc/BRIEF.md
# Auto-Reloading Decrementer Timer

This block is a down-counter that advances on time-base tick enables and signals an event when the count steps down to zero. Each such expiry latches a decrementer status flag inside a 32-bit timer status word. An interrupt request is raised while that flag is set and the decrementer interrupt enable in the shared timer control word is set. When the auto-reload bit of the control word is set at the moment of expiry, the counter takes its next value from a separate reload register, so the event repeats with a fixed period. When that bit is clear, the counter stays at zero until software loads it again.

Software reaches the block through plain write strobes. There is one strobe for the counter, one for the reload register, one for the control word, and one write-one-to-clear strobe for the status word. All of these are single-cycle register writes, so there is no stream interface and no back-pressure. Time-base generation and the other timers that share the control and status words are outside this block. The bit positions used here are fixed, because those other timers decode the same words.

Top module: `dec_timer`

## Requirements
- R1: After reset the counter, the reload register, the control word and the status word all read 0, and `irq` is low.
- R2: While the count is nonzero, each cycle with `tb_tick` high lowers it by exactly one. Without `tb_tick` the count holds.
- R3: A counter write in a cycle wins over a decrement in that same cycle, and a counter write never sets the status flag, even when it lands on zero.
- R4: A decrement from 1 to 0 (an expiry) sets status bit 27, and the flag is visible on `status` in the next cycle.
- R5: `irq` is high exactly when status bit 27 and control bit 26 are both set.
- R6: If control bit 22 is set during an expiry, the counter loads the reload register's value instead of 0. Status bit 27 is still set.
- R7: If control bit 22 is clear, the counter remains at 0 after an expiry. Further ticks produce no event and no change until the counter is written.
- R8: A status write clears every status bit whose write-data bit is 1. Bits written as 0 are unchanged.
- R9: If an expiry and a status write with bit 27 set fall in the same cycle, status bit 27 ends up set.
- R10: The control word stores all 32 written bits and reads them back unchanged on `ctl`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | Time-base tick enable, one decrement per high cycle |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CW | Counter write value |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | CW | Reload register write value |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word value (bit 26 interrupt enable, bit 22 auto-reload) |
| sts_we | input | 1 | Status write-one-to-clear strobe |
| sts_wdata | input | 32 | Status clear mask (bit 27 is the decrementer flag) |
| count | output | CW | Current counter value |
| reload | output | CW | Reload register value |
| ctl | output | 32 | Control word |
| status | output | 32 | Status word |
| irq | output | 1 | Decrementer interrupt request |

## Verification
Every storage element is a single register stage, so each result is due exactly one clock edge after the stimulus that causes it. This holds for a counter or register write, a tick, an expiry, and a status clear. `irq` is a gate on registered state, so it follows its status or control change in that same cycle. The bench changes inputs on the falling edge and reads outputs at the next falling edge, which puts exactly one rising edge between each stimulus and its check. The tick sweeps compare the count and flag after every single tick against a closed-form value computed from the start value, the reload value and the number of ticks.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int REG_W       = 32;
  localparam int CTL_IE_BIT  = 26;
  localparam int CTL_ARE_BIT = 22;
  localparam int STS_DEC_BIT = 27;
endpackage

// File: rtl/dec_count.sv
module dec_count #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          are,
  input  logic [CW-1:0] reload,
  output logic [CW-1:0] count,
  output logic          expire
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] ZERO = '0;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_zero;

  assign at_zero = (cnt_q == ZERO);
  assign expire  = tick && !wr_en && (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en)                  cnt_d = wr_data;
    else if (expire)            cnt_d = are ? reload : ZERO;
    else if (tick && !at_zero)  cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= ZERO;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en && (count > ONE)) |=> (count == $past(count) - ONE)); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(count)); // R2
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_data))); // R3
  AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && are) |=> (count == $past(reload))); // R6
  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !wr_en) |=> (count == ZERO)); // R7
endmodule

// File: rtl/dec_regs.sv
module dec_regs
  import dec_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rld_we,
  input  logic [CW-1:0]    rld_wdata,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  output logic [CW-1:0]    reload,
  output logic [REG_W-1:0] ctl,
  output logic             int_en,
  output logic             auto_rld
);
  logic [CW-1:0]    rld_q;
  logic [REG_W-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_q <= '0;
      ctl_q <= '0;
    end else begin
      if (rld_we) rld_q <= rld_wdata;
      if (ctl_we) ctl_q <= ctl_wdata;
    end
  end

  assign reload   = rld_q;
  assign ctl      = ctl_q;
  assign int_en   = ctl_q[CTL_IE_BIT];
  assign auto_rld = ctl_q[CTL_ARE_BIT];

  AST_CTL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl == $past(ctl_wdata))); // R10
endmodule

// File: rtl/dec_flag.sv
module dec_flag
  import dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             clr_we,
  input  logic [REG_W-1:0] clr_mask,
  input  logic             int_en,
  output logic [REG_W-1:0] status,
  output logic             irq
);
  logic [REG_W-1:0] sts_q, sts_d;

  always_comb begin
    sts_d = sts_q;
    if (clr_we) sts_d = sts_d & ~clr_mask;
    if (expire) sts_d[STS_DEC_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  assign status = sts_q;
  assign irq    = sts_q[STS_DEC_BIT] & int_en;

  AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status[STS_DEC_BIT]); // R4
  AST_ONLY_EXPIRE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[STS_DEC_BIT]) |-> $past(expire)); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_mask[STS_DEC_BIT] && !expire) |=> !status[STS_DEC_BIT]); // R8
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status[STS_DEC_BIT]); // R5
endmodule

// File: rtl/dec_timer.sv
module dec_timer
  import dec_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_tick,
  input  logic             cnt_we,
  input  logic [CW-1:0]    cnt_wdata,
  input  logic             rld_we,
  input  logic [CW-1:0]    rld_wdata,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             sts_we,
  input  logic [REG_W-1:0] sts_wdata,
  output logic [CW-1:0]    count,
  output logic [CW-1:0]    reload,
  output logic [REG_W-1:0] ctl,
  output logic [REG_W-1:0] status,
  output logic             irq
);
  logic int_en, auto_rld, expire;

  dec_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .rld_we(rld_we), .rld_wdata(rld_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .reload(reload), .ctl(ctl),
    .int_en(int_en), .auto_rld(auto_rld)
  );

  dec_count #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tb_tick),
    .wr_en(cnt_we), .wr_data(cnt_wdata),
    .are(auto_rld), .reload(reload),
    .count(count), .expire(expire)
  );

  dec_flag u_flag (
    .clk(clk), .rst_n(rst_n), .expire(expire),
    .clr_we(sts_we), .clr_mask(sts_wdata),
    .int_en(int_en), .status(status), .irq(irq)
  );

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctl[CTL_IE_BIT]); // R5
  AST_SAME_CYCLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> status[STS_DEC_BIT]); // R9
endmodule

// File: tb/test_dec_timer.sv
module test_dec_timer;
  localparam int CW = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int IE = 26, ARE = 22, DS = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_tick = 1'b0, cnt_we = 1'b0, rld_we = 1'b0, ctl_we = 1'b0, sts_we = 1'b0;
  logic [CW-1:0] cnt_wdata = '0, rld_wdata = '0;
  logic [31:0] ctl_wdata = '0, sts_wdata = '0;
  logic [CW-1:0] count, reload;
  logic [31:0] ctl, status;
  logic irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_timer #(.CW(CW)) i_dec_timer (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .rld_we(rld_we), .rld_wdata(rld_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .sts_we(sts_we), .sts_wdata(sts_wdata),
    .count(count), .reload(reload), .ctl(ctl), .status(status), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    tb_tick = 0; cnt_we = 0; rld_we = 0; ctl_we = 0; sts_we = 0;
  endtask

  task automatic wr_cnt(input int v);
    cnt_we = 1; cnt_wdata = CW'(v); step();
  endtask
  task automatic wr_rld(input int v);
    rld_we = 1; rld_wdata = CW'(v); step();
  endtask
  task automatic wr_ctl(input logic [31:0] v);
    ctl_we = 1; ctl_wdata = v; step();
  endtask
  task automatic clr_sts(input logic [31:0] m);
    sts_we = 1; sts_wdata = m; step();
  endtask

  function automatic int exp_cnt(int s, int r, bit are, int k);
    if (s == 0) return 0;
    if (k < s) return s - k;
    if (!are || r == 0) return 0;
    return r - ((k - s) % r);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(count == 0, "R1 count", count, 0);
    chk(reload == 0, "R1 reload", reload, 0);
    chk(ctl == 0, "R1 ctl", ctl, 0);
    chk(status == 0, "R1 status", status, 0);
    chk(irq == 0, "R1 irq", irq, 0);

    // R10 control read back
    wr_ctl(32'hA5C3_0F96);
    chk(ctl == 32'hA5C3_0F96, "R10 ctl", ctl, 32'hA5C3_0F96);
    wr_ctl(32'h0);

    // R2 R4 R7 sweep without auto-reload
    for (int s = 0; s <= 12; s++) begin
      wr_cnt(s);
      clr_sts(32'hFFFF_FFFF);
      for (int k = 1; k <= 16; k++) begin
        tb_tick = 1; step();
        chk(count == CW'(exp_cnt(s, 0, 0, k)), "R2/R7 count", count, exp_cnt(s, 0, 0, k));
        chk(status[DS] == (s > 0 && k >= s), "R4 flag", status[DS], (s > 0 && k >= s));
      end
    end

    // R6 sweep with auto-reload
    wr_ctl(32'h1 << ARE);
    for (int s = 1; s <= 6; s++) begin
      for (int r = 0; r <= 4; r++) begin
        wr_rld(r);
        wr_cnt(s);
        clr_sts(32'h1 << DS);
        for (int k = 1; k <= 14; k++) begin
          tb_tick = 1; step();
          chk(count == CW'(exp_cnt(s, r, 1, k)), "R6 count", count, exp_cnt(s, r, 1, k));
          chk(status[DS] == (k >= s), "R6 flag", status[DS], (k >= s));
        end
      end
    end
    wr_ctl(32'h0);

    // R2 hold without tick
    wr_cnt(7);
    repeat (4) step();
    chk(count == 7, "R2 hold", count, 7);

    // R3 write priority
    clr_sts(32'h1 << DS);
    tb_tick = 1; cnt_we = 1; cnt_wdata = 9; step();
    chk(count == 9, "R3 write wins", count, 9);
    wr_cnt(1);
    tb_tick = 1; cnt_we = 1; cnt_wdata = 0; step();
    chk(count == 0, "R3 write zero", count, 0);
    chk(status[DS] == 0, "R3 no flag", status[DS], 0);

    // R5 gating
    wr_cnt(1);
    tb_tick = 1; step();
    chk(status[DS] == 1 && irq == 0, "R5 gated off", irq, 0);
    wr_ctl(32'h1 << IE);
    chk(irq == 1, "R5 enabled", irq, 1);

    // R8 write-one-to-clear
    clr_sts(~(32'h1 << DS));
    chk(status[DS] == 1, "R8 zero bit keeps", status[DS], 1);
    clr_sts(32'h1 << DS);
    chk(status[DS] == 0, "R8 clear", status[DS], 0);
    chk(irq == 0, "R8 irq drop", irq, 0);

    // R9 expiry and clear in same cycle
    wr_cnt(1);
    tb_tick = 1; sts_we = 1; sts_wdata = 32'h1 << DS; step();
    chk(status[DS] == 1, "R9 set wins", status[DS], 1);
    chk(irq == 1, "R9 irq", irq, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule